// File: doc/BRIEF.md
# Shared Memory Port Arbiter

This block sits between the fetch stage and the memory stage of a five-stage pipeline that owns a single-port synchronous memory. The fetch stage offers a PC with a request. The memory stage offers a load or a store with address, write data and byte enables. One port cannot serve both in a cycle, so the data side always takes it. In that cycle the block raises a stall toward fetch, which holds the PC and the fetch/decode register. The request is not queued: fetch repeats the same PC once the data access is done.

Read data comes back one cycle after the request. A registered owner tag sends it to exactly one side. A fetch return carries a valid flag. A cycle with no fetch return presents a NOP word, so a held fetch/decode register never passes a duplicate instruction downstream. The memory array is modelled inside the block as four byte lanes.

Top module: `shared_port_arb`

## Requirements
- R1: When fetch and data request in the same cycle, the data access uses the port. The next cycle has no fetch return (`fetch_valid_o` low) and serves the data side.
- R2: `fetch_stall_o` is high in exactly those cycles in which `data_req_i` is high, whatever the state of `fetch_req_i`.
- R3: A load (`data_req_i` high, `data_we_i` low) returns the addressed word on `data_rdata_o` with `data_rvalid_o` high in the next cycle, and `fetch_valid_o` is low in that cycle.
- R4: A fetch with no data request returns the addressed word on `fetch_instr_o` with `fetch_valid_o` high in the next cycle, and `data_rvalid_o` is low in that cycle.
- R5: A store writes byte k of the word (bits 8k+7..8k) only when bit k of `data_be_i` is set. The other bytes keep their value. The next cycle raises neither `fetch_valid_o` nor `data_rvalid_o`.
- R6: In any cycle in which `fetch_valid_o` is low, `fetch_instr_o` equals the NOP word 32'h0000_0013.
- R7: Address bits 1..0 are ignored on both sides. Every access is one aligned 32-bit word selected by the upper address bits.
- R8: While reset is asserted, and in the cycle after an idle cycle, neither side has a valid return. During reset `fetch_instr_o` holds the NOP word.
- R9: Data requests in consecutive cycles keep `fetch_stall_o` high in each of those cycles. A fetch of the held PC that follows them returns the word at that PC.
- R10: `data_rdata_o` is zero in any cycle in which `data_rvalid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_req_i | input | 1 | Fetch request |
| fetch_pc_i | input | ADDR_W | Fetch byte address |
| fetch_stall_o | output | 1 | Hold PC and fetch/decode register |
| fetch_valid_o | output | 1 | Fetch word returned this cycle |
| fetch_instr_o | output | 32 | Fetched word, NOP when not valid |
| data_req_i | input | 1 | Load or store request |
| data_we_i | input | 1 | 1 = store, 0 = load |
| data_addr_i | input | ADDR_W | Data byte address |
| data_wdata_i | input | 32 | Store data |
| data_be_i | input | 4 | Store byte enables |
| data_rvalid_o | output | 1 | Load data returned this cycle |
| data_rdata_o | output | 32 | Load data, zero when not valid |

## Verification
The stall is combinational, so the bench checks it 1 ns after driving the inputs, in the same cycle. Returned data and valid flags come one clock edge after the request. The bench drives each request on a falling edge and samples all return outputs on the next falling edge, before it changes any input. A reference word array in the bench applies each store's byte enables and predicts the result. Random request patterns run alongside directed cases: a collision, a partial store, unaligned addresses, a run of data operations with a held PC, and idle cycles.

// File: rtl/mem_arb_pkg.sv
package mem_arb_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam logic [WORD_W-1:0] NOP_WORD = 32'h0000_0013;

  typedef enum logic [1:0] {
    OWN_IDLE  = 2'd0,
    OWN_FETCH = 2'd1,
    OWN_DATA  = 2'd2
  } owner_e;
endpackage

// File: rtl/mem_arb_grant.sv
module mem_arb_grant
  import mem_arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned IDX_W = ADDR_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  input  logic              data_req_i,
  input  logic              data_we_i,
  input  logic [ADDR_W-1:0] data_addr_i,
  input  logic [WORD_W-1:0] data_wdata_i,
  input  logic [LANES-1:0]  data_be_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [IDX_W-1:0]  mem_idx_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic [LANES-1:0]  mem_be_o,
  output logic              fetch_stall_o,
  output owner_e            owner_o
);
  logic [ADDR_W-1:0] addr_sel;
  logic              unused_lo;
  owner_e            owner_q, owner_d;

  // data side always wins the port
  assign addr_sel      = data_req_i ? data_addr_i : fetch_pc_i;
  assign mem_idx_o     = addr_sel[ADDR_W-1:2];
  assign unused_lo     = ^addr_sel[1:0];
  assign mem_en_o      = data_req_i | fetch_req_i;
  assign mem_we_o      = data_req_i & data_we_i;
  assign mem_wdata_o   = data_wdata_i;
  assign mem_be_o      = data_be_i;
  assign fetch_stall_o = data_req_i;

  always_comb begin
    owner_d = OWN_IDLE;
    if (data_req_i) owner_d = data_we_i ? OWN_IDLE : OWN_DATA;
    else if (fetch_req_i) owner_d = OWN_FETCH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owner_q <= OWN_IDLE;
    else         owner_q <= owner_d;
  end

  assign owner_o = owner_q;

  AST_DATA_OWNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_req_i && !data_we_i |=> owner_q == OWN_DATA); // R3
endmodule

// File: rtl/mem_arb_sram.sv
module mem_arb_sram
  import mem_arb_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [LANES-1:0]  be_i,
  output logic [WORD_W-1:0] rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    logic [7:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (en_i && we_i && be_i[g]) lane_mem[idx_i] <= wdata_i[8*g +: 8];
    end

    always_ff @(posedge clk_i) begin
      if (en_i && !we_i) rd_q <= lane_mem[idx_i];
    end

    assign rdata_o[8*g +: 8] = rd_q;
  end
endmodule

// File: rtl/mem_arb_route.sv
module mem_arb_route
  import mem_arb_pkg::*;
(
  input  owner_e            owner_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic              fetch_valid_o,
  output logic [WORD_W-1:0] fetch_instr_o,
  output logic              data_rvalid_o,
  output logic [WORD_W-1:0] data_rdata_o
);
  assign fetch_valid_o = (owner_i == OWN_FETCH);
  assign data_rvalid_o = (owner_i == OWN_DATA);
  // a non-valid fetch slot carries a NOP so a held decode register cannot duplicate
  assign fetch_instr_o = fetch_valid_o ? rdata_i : NOP_WORD;
  assign data_rdata_o  = data_rvalid_o ? rdata_i : '0;
endmodule

// File: rtl/shared_port_arb.sv
module shared_port_arb
  import mem_arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned IDX_W = ADDR_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  output logic              fetch_stall_o,
  output logic              fetch_valid_o,
  output logic [31:0]       fetch_instr_o,
  input  logic              data_req_i,
  input  logic              data_we_i,
  input  logic [ADDR_W-1:0] data_addr_i,
  input  logic [31:0]       data_wdata_i,
  input  logic [3:0]        data_be_i,
  output logic              data_rvalid_o,
  output logic [31:0]       data_rdata_o
);
  logic              mem_en, mem_we;
  logic [IDX_W-1:0]  mem_idx;
  logic [WORD_W-1:0] mem_wdata, mem_rdata;
  logic [LANES-1:0]  mem_be;
  owner_e            owner;

  mem_arb_grant #(.ADDR_W(ADDR_W)) u_grant (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fetch_req_i   (fetch_req_i),
    .fetch_pc_i    (fetch_pc_i),
    .data_req_i    (data_req_i),
    .data_we_i     (data_we_i),
    .data_addr_i   (data_addr_i),
    .data_wdata_i  (data_wdata_i),
    .data_be_i     (data_be_i),
    .mem_en_o      (mem_en),
    .mem_we_o      (mem_we),
    .mem_idx_o     (mem_idx),
    .mem_wdata_o   (mem_wdata),
    .mem_be_o      (mem_be),
    .fetch_stall_o (fetch_stall_o),
    .owner_o       (owner)
  );

  mem_arb_sram #(.IDX_W(IDX_W)) u_sram (
    .clk_i   (clk_i),
    .en_i    (mem_en),
    .we_i    (mem_we),
    .idx_i   (mem_idx),
    .wdata_i (mem_wdata),
    .be_i    (mem_be),
    .rdata_o (mem_rdata)
  );

  mem_arb_route u_route (
    .owner_i       (owner),
    .rdata_i       (mem_rdata),
    .fetch_valid_o (fetch_valid_o),
    .fetch_instr_o (fetch_instr_o),
    .data_rvalid_o (data_rvalid_o),
    .data_rdata_o  (data_rdata_o)
  );

  AST_DATA_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_req_i && fetch_req_i |=> !fetch_valid_o); // R1
  AST_FETCH_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_i && !data_req_i |=> fetch_valid_o && !data_rvalid_o); // R4
  AST_STORE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_req_i && data_we_i |=> !data_rvalid_o && !fetch_valid_o); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_req_i && !fetch_req_i |=> !data_rvalid_o && !fetch_valid_o); // R8
  AST_NO_FETCH_UNDER_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_stall_o |=> !fetch_valid_o); // R2
endmodule

// File: tb/sim_shared_port_arb.sv
module sim_shared_port_arb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam logic [31:0] NOP = 32'h0000_0013;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic fetch_req_i = 1'b0, data_req_i = 1'b0, data_we_i = 1'b0;
  logic [AW-1:0] fetch_pc_i = '0, data_addr_i = '0;
  logic [31:0] data_wdata_i = '0;
  logic [3:0] data_be_i = '0;
  logic fetch_stall_o, fetch_valid_o, data_rvalid_o;
  logic [31:0] fetch_instr_o, data_rdata_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] ref_mem [16];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  shared_port_arb #(.ADDR_W(AW)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  // called at a falling edge; returns at the next falling edge after checking results
  task automatic step(input string stall_tag, input bit f_req, input logic [AW-1:0] pc,
                      input bit d_req, input bit we, input logic [AW-1:0] addr,
                      input logic [31:0] wd, input logic [3:0] be);
    bit ev_f, ev_d;
    logic [31:0] ei_f, ei_d;
    fetch_req_i = f_req; fetch_pc_i = pc;
    data_req_i = d_req; data_we_i = we; data_addr_i = addr;
    data_wdata_i = wd; data_be_i = be;
    #1;
    chk(stall_tag, {31'd0, fetch_stall_o}, {31'd0, d_req});
    ev_f = f_req && !d_req;
    ev_d = d_req && !we;
    ei_f = ev_f ? ref_mem[pc[5:2]] : NOP;
    ei_d = ev_d ? ref_mem[addr[5:2]] : 32'd0;
    if (d_req && we) ref_mem[addr[5:2]] = merge(ref_mem[addr[5:2]], wd, be);
    @(negedge clk_i);
    chk((d_req && f_req) ? "R1" : "R4", {31'd0, fetch_valid_o}, {31'd0, ev_f});
    chk((d_req && we) ? "R5" : "R3", {31'd0, data_rvalid_o}, {31'd0, ev_d});
    chk(ev_f ? ((pc[1:0] != 2'd0) ? "R7" : "R4") : "R6", fetch_instr_o, ei_f);
    chk(ev_d ? ((addr[1:0] != 2'd0) ? "R7" : "R3") : "R10", data_rdata_o, ei_d);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk_i);
    chk("R8", {31'd0, fetch_valid_o}, 32'd0);
    chk("R8", {31'd0, data_rvalid_o}, 32'd0);
    chk("R8", fetch_instr_o, NOP);
    chk("R8", {31'd0, fetch_stall_o}, 32'd0);
    rst_ni = 1'b1;
    for (int i = 0; i < 16; i++) ref_mem[i] = 32'd0;
    // fill every used word with full stores
    for (int i = 0; i < 16; i++)
      step("R2", 1'b0, '0, 1'b1, 1'b1, AW'(i * 4), $urandom, 4'hF);
    // idle cycle
    step("R2", 1'b0, '0, 1'b0, 1'b0, '0, '0, '0);
    // partial store then load back
    step("R5", 1'b0, '0, 1'b1, 1'b1, AW'(12), 32'hAABB_CCDD, 4'b0101);
    step("R5", 1'b0, '0, 1'b1, 1'b0, AW'(12), '0, '0);
    chk("R5", data_rdata_o, ref_mem[3]);
    // unaligned addresses on both sides
    step("R2", 1'b1, AW'(22), 1'b0, 1'b0, '0, '0, '0);
    step("R2", 1'b0, '0, 1'b1, 1'b0, AW'(31), '0, '0);
    // collision: data wins
    step("R2", 1'b1, AW'(8), 1'b1, 1'b0, AW'(40), '0, '0);
    step("R2", 1'b1, AW'(8), 1'b1, 1'b1, AW'(44), 32'h1234_5678, 4'hF);
    // back-to-back data ops with PC held, then resume
    step("R9", 1'b1, AW'(16), 1'b1, 1'b1, AW'(20), 32'hDEAD_BEEF, 4'hF);
    step("R9", 1'b1, AW'(16), 1'b1, 1'b0, AW'(20), '0, '0);
    step("R9", 1'b1, AW'(16), 1'b1, 1'b1, AW'(16), 32'h0BAD_F00D, 4'b1100);
    step("R9", 1'b1, AW'(16), 1'b0, 1'b0, '0, '0, '0);
    chk("R9", fetch_instr_o, ref_mem[4]);
    chk("R9", {31'd0, fetch_valid_o}, 32'd1);
    // random mix
    for (int n = 0; n < 400; n++) begin
      bit fr = 1'($urandom);
      bit dr = ($urandom % 3) == 0;
      step("R2", fr, AW'($urandom % 64), dr, 1'($urandom), AW'($urandom % 64),
           $urandom, 4'($urandom));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule